// File: doc/BRIEF.md
# Ethernet Transmit Frame Sequencer

This block walks one outgoing Ethernet frame from a byte source onto a byte-wide transmit interface. Once transmission is enabled and the source signals that a frame is waiting, a fixed preamble interval runs, and then the payload is read one byte per cycle. If the frame is below the minimum size and padding is on, zero bytes follow. Unless CRC append is switched off, four CRC bytes come last. The CRC bytes come from an external generator, which is represented here by a request strobe and a 32-bit value input.

The sequencer can also watch its own carrier while it transmits. If that carrier is missing when the preamble ends, or drops during the frame, the frame is abandoned with no CRC. A stop on an SQE test error can be enabled. Every stop caused by an error raises a one-cycle pulse, and the surrounding control register uses that pulse to clear its transmit-enable bit. Clearing the enable from outside is a graceful stop: the frame in flight still completes.

Top module: `eth_tx_sequencer`

## Requirements
- R1: When enable and frame-ready are both high in idle, a frame starts. Exactly 8 cycles with tx_valid low follow, then the payload bytes appear on tx_data, one per cycle, each popped with buf_rd. A new frame does not start in a cycle where frm_done, frm_abort or err_clr_en is high.
- R2: With no-CRC low, four bytes of crc_value follow the payload and any padding, least significant byte first. crc_req is high for exactly one cycle, the cycle of the first CRC byte.
- R3: With pad enable high, a payload shorter than the pad goal is followed by 0x00 bytes up to the goal. The pad goal is 60 bytes with CRC appended and 64 bytes without, so every padded frame is 64 bytes on the wire.
- R4: With pad enable low, or with a payload already at or above the pad goal, the payload is sent unchanged in length.
- R5: With no-CRC high, nothing is appended after the payload or padding.
- R6: With carrier monitoring high, the frame is aborted if carrier_in is low in the last preamble cycle or in any byte cycle. That cycle carries no tx_valid, no CRC is sent, and frm_abort pulses for one cycle in the next cycle.
- R7: With carrier monitoring low, carrier_in has no effect on the frame.
- R8: The enable is sampled only when a frame starts. Lowering it mid-frame still lets that frame complete in full. While it is low, no frame starts and buf_rd stays low.
- R9: With stop-on-SQE high, an sqe_err pulse causes an error stop, and it also aborts a frame in progress. With stop-on-SQE low, sqe_err is ignored and the next frame is sent normally.
- R10: err_clr_en pulses for one cycle after every abort and every SQE error stop, and never after a completed frame. frm_done pulses for one cycle in the cycle after the last byte.
- R11: During reset, tx_valid, buf_rd, crc_req, frm_done, frm_abort and err_clr_en are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tx_en | input | 1 | Transmit enable level |
| cfg_pad_en | input | 1 | Pad short frames with zeros |
| cfg_no_crc | input | 1 | Do not append CRC |
| cfg_mon_carrier | input | 1 | Abort on missing or lost own carrier |
| cfg_stop_sqe | input | 1 | Stop on SQE test error |
| frm_ready | input | 1 | Source holds a complete frame |
| buf_data | input | 8 | Current source byte (show-ahead) |
| buf_last | input | 1 | Current source byte is the last one |
| buf_rd | output | 1 | Pop the current source byte |
| carrier_in | input | 1 | Carrier sense |
| sqe_err | input | 1 | SQE test error pulse |
| crc_req | output | 1 | Strobe on the first CRC byte |
| crc_value | input | 32 | CRC from the external generator |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | tx_data is a frame byte |
| frm_done | output | 1 | Frame completed (one cycle) |
| frm_abort | output | 1 | Frame aborted (one cycle) |
| err_clr_en | output | 1 | Error stop; clears the enable (one cycle) |

## Verification
A wrong length count shows up on the wire at the padding boundary. A frame of 59, 60, 61 or 63 bytes then comes out one byte short or one byte long, and the error is visible at the cycle where CRC or frm_done should appear. A wrong state choice shows the same cycle it happens: a zero byte where a CRC byte belongs, CRC after an abort, or a missing frm_done one cycle after the last byte. An error in the carrier or SQE gating shows either as a tx_valid byte in the cycle the carrier is low, or as a missing err_clr_en pulse in the next cycle.

// File: rtl/eth_txs_pkg.sv
package eth_txs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_PAD,
        ST_CRC
    } txs_state_e;

    typedef enum logic [1:0] {
        SRC_BUF,
        SRC_ZERO,
        SRC_CRC
    } txs_src_e;

    // Data length that padding must reach so the wire frame hits the minimum.
    function automatic int unsigned pad_goal(input int unsigned min_len,
                                             input int unsigned crc_len,
                                             input logic        no_crc);
        return no_crc ? min_len : (min_len - crc_len);
    endfunction

endpackage

// File: rtl/txs_counter.sv
module txs_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/txs_out_mux.sv
module txs_out_mux
    import eth_txs_pkg::*;
#(
    parameter int CRC_BYTES = 4,
    localparam int IDX_W = $clog2(CRC_BYTES)
) (
    input  txs_src_e               sel,
    input  logic [7:0]             buf_byte,
    input  logic [8*CRC_BYTES-1:0] crc_word,
    input  logic [IDX_W-1:0]       crc_idx,
    output logic [7:0]             out_byte
);
    logic [7:0] crc_lane [CRC_BYTES];

    for (genvar g = 0; g < CRC_BYTES; g++) begin : g_lane
        assign crc_lane[g] = crc_word[8*g +: 8];
    end

    always_comb begin
        case (sel)
            SRC_BUF:  out_byte = buf_byte;
            SRC_CRC:  out_byte = crc_lane[crc_idx];
            default:  out_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/eth_tx_sequencer.sv
module eth_tx_sequencer
    import eth_txs_pkg::*;
#(
    parameter int MIN_FRAME  = 64,
    parameter int CRC_BYTES  = 4,
    parameter int PRE_CYCLES = 8,
    parameter int LEN_W      = 11
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_tx_en,
    input  logic        cfg_pad_en,
    input  logic        cfg_no_crc,
    input  logic        cfg_mon_carrier,
    input  logic        cfg_stop_sqe,
    input  logic        frm_ready,
    input  logic [7:0]  buf_data,
    input  logic        buf_last,
    output logic        buf_rd,
    input  logic        carrier_in,
    input  logic        sqe_err,
    output logic        crc_req,
    input  logic [31:0] crc_value,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    output logic        frm_done,
    output logic        frm_abort,
    output logic        err_clr_en
);
    localparam int PH_MAX = (PRE_CYCLES > CRC_BYTES) ? PRE_CYCLES : CRC_BYTES;
    localparam int PH_W   = $clog2(PH_MAX);
    localparam int IDX_W  = $clog2(CRC_BYTES);
    localparam logic [LEN_W-1:0] GOAL_CRC = LEN_W'(pad_goal(MIN_FRAME, CRC_BYTES, 1'b0));
    localparam logic [LEN_W-1:0] GOAL_RAW = LEN_W'(pad_goal(MIN_FRAME, CRC_BYTES, 1'b1));

    txs_state_e       state_q, state_d;
    logic [PH_W-1:0]  phase_q;
    logic [LEN_W-1:0] len_q, len_next, goal;
    logic             done_q, abort_q, err_q;
    logic             hold, carrier_bad, sqe_stop, in_tx, pre_last, crc_last;
    logic             abort_now, need_pad;
    txs_src_e         src_sel;

    assign hold        = done_q || abort_q || err_q;
    assign carrier_bad = cfg_mon_carrier && !carrier_in;
    assign sqe_stop    = cfg_stop_sqe && sqe_err;
    assign in_tx       = (state_q == ST_DATA) || (state_q == ST_PAD) || (state_q == ST_CRC);
    assign pre_last    = (state_q == ST_PRE) && (phase_q == PH_W'(PRE_CYCLES - 1));
    assign crc_last    = (phase_q == PH_W'(CRC_BYTES - 1));
    assign len_next    = len_q + LEN_W'(1);
    assign goal        = cfg_no_crc ? GOAL_RAW : GOAL_CRC;
    assign need_pad    = cfg_pad_en && (len_next < goal);

    always_comb begin
        abort_now = 1'b0;
        if (state_q == ST_PRE) begin
            abort_now = sqe_stop || (pre_last && carrier_bad);
        end else if (in_tx) begin
            abort_now = sqe_stop || carrier_bad;
        end
    end

    assign tx_valid = in_tx && !abort_now;
    assign buf_rd   = (state_q == ST_DATA) && !abort_now;
    assign crc_req  = (state_q == ST_CRC) && (phase_q == '0) && !abort_now;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (cfg_tx_en && frm_ready && !hold) state_d = ST_PRE;
            ST_PRE: begin
                if (abort_now)     state_d = ST_IDLE;
                else if (pre_last) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (abort_now)        state_d = ST_IDLE;
                else if (buf_last) begin
                    if (need_pad)         state_d = ST_PAD;
                    else if (!cfg_no_crc) state_d = ST_CRC;
                    else                  state_d = ST_IDLE;
                end
            end
            ST_PAD: begin
                if (abort_now)              state_d = ST_IDLE;
                else if (len_next >= goal)  state_d = cfg_no_crc ? ST_IDLE : ST_CRC;
            end
            ST_CRC: begin
                if (abort_now)     state_d = ST_IDLE;
                else if (crc_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            abort_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= tx_valid && (state_d == ST_IDLE);
            abort_q <= abort_now;
            err_q   <= abort_now || sqe_stop;
        end
    end

    assign frm_done   = done_q;
    assign frm_abort  = abort_q;
    assign err_clr_en = err_q;

    txs_counter #(.W(PH_W)) u_phase (
        .clk (clk),
        .rst (rst),
        .clr (state_d != state_q),
        .inc (1'b1),
        .cnt (phase_q)
    );

    txs_counter #(.W(LEN_W)) u_len (
        .clk (clk),
        .rst (rst),
        .clr (state_q == ST_IDLE),
        .inc (tx_valid && (state_q != ST_CRC)),
        .cnt (len_q)
    );

    always_comb begin
        case (state_q)
            ST_PAD:  src_sel = SRC_ZERO;
            ST_CRC:  src_sel = SRC_CRC;
            default: src_sel = SRC_BUF;
        endcase
    end

    txs_out_mux #(.CRC_BYTES(CRC_BYTES)) u_mux (
        .sel      (src_sel),
        .buf_byte (buf_data),
        .crc_word (crc_value[8*CRC_BYTES-1:0]),
        .crc_idx  (phase_q[IDX_W-1:0]),
        .out_byte (tx_data)
    );
endmodule

// File: rtl/txs_checker.sv
module txs_checker
    import eth_txs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input txs_state_e state,
    input logic       cfg_tx_en,
    input logic       cfg_mon_carrier,
    input logic       carrier_in,
    input logic       tx_valid,
    input logic [7:0] tx_data,
    input logic       crc_req,
    input logic       frm_done,
    input logic       frm_abort,
    input logic       err_clr_en
);
    a_r1_valid_in_frame: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (state == ST_DATA || state == ST_PAD || state == ST_CRC));

    a_r2_crc_req_single: assert property (@(posedge clk) disable iff (rst)
        crc_req |=> !crc_req);

    a_r3_pad_zero: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PAD && tx_valid) |-> (tx_data == 8'h00));

    a_r6_carrier_gate: assert property (@(posedge clk) disable iff (rst)
        (cfg_mon_carrier && !carrier_in) |-> !tx_valid);

    a_r8_no_start_disabled: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !cfg_tx_en) |=> (state == ST_IDLE));

    a_r10_abort_raises_err: assert property (@(posedge clk) disable iff (rst)
        frm_abort |-> err_clr_en);

    a_r10_done_abort_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frm_done, frm_abort}));
endmodule

bind eth_tx_sequencer txs_checker u_txs_checker (
    .clk             (clk),
    .rst             (rst),
    .state           (state_q),
    .cfg_tx_en       (cfg_tx_en),
    .cfg_mon_carrier (cfg_mon_carrier),
    .carrier_in      (carrier_in),
    .tx_valid        (tx_valid),
    .tx_data         (tx_data),
    .crc_req         (crc_req),
    .frm_done        (frm_done),
    .frm_abort       (frm_abort),
    .err_clr_en      (err_clr_en)
);

// File: tb/test_eth_tx_sequencer.sv
module test_eth_tx_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] CRC_K = 32'hC0FFEE42;

    typedef struct packed {
        int len;
        bit pad;
        bit nocrc;
        int total;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{10, 1'b1, 1'b0, 64},
        '{10, 1'b0, 1'b0, 14},
        '{10, 1'b1, 1'b1, 64},
        '{70, 1'b1, 1'b0, 74},
        '{60, 1'b1, 1'b0, 64},
        '{59, 1'b1, 1'b0, 64},
        '{61, 1'b1, 1'b0, 65},
        '{63, 1'b1, 1'b1, 64},
        '{1,  1'b0, 1'b1, 1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_tx_en = 1'b0, cfg_pad_en = 1'b0, cfg_no_crc = 1'b0;
    logic cfg_mon_carrier = 1'b0, cfg_stop_sqe = 1'b0;
    logic frm_ready = 1'b0, carrier_in = 1'b1, sqe_err = 1'b0;
    logic [7:0] buf_data;
    logic buf_last, buf_rd, crc_req, tx_valid, frm_done, frm_abort, err_clr_en;
    logic [7:0] tx_data;

    int src_len = 1;
    int src_idx = 0;
    logic src_rst = 1'b0;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] src_byte(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    assign buf_data = src_byte(src_idx);
    assign buf_last = (src_idx == src_len - 1);

    always @(posedge clk) begin
        if (src_rst)     src_idx <= 0;
        else if (buf_rd) src_idx <= src_idx + 1;
    end

    eth_tx_sequencer i_eth_tx_sequencer (
        .clk(clk), .rst(rst), .cfg_tx_en(cfg_tx_en), .cfg_pad_en(cfg_pad_en),
        .cfg_no_crc(cfg_no_crc), .cfg_mon_carrier(cfg_mon_carrier),
        .cfg_stop_sqe(cfg_stop_sqe), .frm_ready(frm_ready), .buf_data(buf_data),
        .buf_last(buf_last), .buf_rd(buf_rd), .carrier_in(carrier_in),
        .sqe_err(sqe_err), .crc_req(crc_req), .crc_value(CRC_K),
        .tx_data(tx_data), .tx_valid(tx_valid), .frm_done(frm_done),
        .frm_abort(frm_abort), .err_clr_en(err_clr_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected wire byte k, from the padding and CRC rules alone.
    function automatic logic [7:0] exp_byte(input int k, input int len,
                                            input bit pad, input bit nocrc);
        int goal;
        int plen;
        goal = nocrc ? 64 : 60;
        plen = (pad && len < goal) ? goal : len;
        if (k < len)  return src_byte(k);
        if (k < plen) return 8'h00;
        return CRC_K[8*(k-plen) +: 8];
    endfunction

    task automatic run_frame(input int len, input bit pad, input bit nocrc,
                             input bit mon, input int drop_at, input int dis_at,
                             input bit exp_abort, input int exp_total,
                             input bit chk_pre, input string req);
        int cnt = 0, pre = 0, mism = 0, errs = 0, crcq = 0, gap_valid = 0;
        bit first = 0, done = 0, abort = 0;
        @(negedge clk);
        cfg_pad_en = pad; cfg_no_crc = nocrc; cfg_mon_carrier = mon;
        src_len = len; src_rst = 1'b1;
        @(negedge clk);
        src_rst = 1'b0; frm_ready = 1'b1;
        for (int c = 0; c < 400 && !done && !abort; c++) begin
            @(negedge clk);
            if (tx_valid) begin
                if (tx_data !== exp_byte(cnt, len, pad, nocrc)) mism++;
                if (mon && !carrier_in) gap_valid++;
                cnt++;
                first = 1;
                if (drop_at >= 0 && cnt == drop_at) carrier_in = 1'b0;
                if (dis_at >= 0 && cnt == dis_at) cfg_tx_en = 1'b0;
            end else if (!first) begin
                pre++;
            end
            if (crc_req) crcq++;
            if (err_clr_en) begin errs++; cfg_tx_en = 1'b0; end
            if (frm_done) done = 1;
            if (frm_abort) abort = 1;
        end
        frm_ready = 1'b0;
        chk(cnt == exp_total, req, "byte count", cnt, exp_total);
        chk(mism == 0, req, "byte mismatches", mism, 0);
        chk(gap_valid == 0, req, "valid while carrier low", gap_valid, 0);
        chk(abort == exp_abort, req, "abort seen", abort, exp_abort);
        chk(done == !exp_abort, req, "done seen", done, !exp_abort);
        chk(errs == int'(exp_abort), "R10", "err pulses", errs, int'(exp_abort));
        chk(crcq == int'(!exp_abort && !nocrc), "R2", "crc_req count",
            crcq, int'(!exp_abort && !nocrc));
        if (chk_pre) chk(pre == 8, "R1", "preamble gap", pre, 8);
        repeat (3) @(negedge clk);
        carrier_in = 1'b1;
        cfg_tx_en = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        int seen;
        repeat (3) @(negedge clk);
        // R11: quiet outputs in reset
        chk({tx_valid, buf_rd, crc_req, frm_done, frm_abort, err_clr_en} == 6'b0,
            "R11", "outputs in reset",
            int'({tx_valid, buf_rd, crc_req, frm_done, frm_abort, err_clr_en}), 0);
        rst = 1'b0;
        @(negedge clk);

        // R8: enable low, frame waiting, nothing starts
        frm_ready = 1'b1; seen = 0;
        repeat (30) begin @(negedge clk); if (tx_valid || buf_rd) seen++; end
        frm_ready = 1'b0;
        chk(seen == 0, "R8", "activity while disabled", seen, 0);
        cfg_tx_en = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R3 R4 R5: table of lengths and modes
        for (int v = 0; v < NV; v++) begin
            run_frame(VECS[v].len, VECS[v].pad, VECS[v].nocrc, 1'b0, -1, -1,
                      1'b0, VECS[v].total, 1'b1, "R3/R4/R5");
        end

        // R7: monitoring off, carrier absent, frame completes
        carrier_in = 1'b0;
        run_frame(10, 1'b0, 1'b0, 1'b0, -1, -1, 1'b0, 14, 1'b1, "R7");

        // R6: monitoring on, no carrier by end of preamble
        carrier_in = 1'b0;
        run_frame(20, 1'b1, 1'b0, 1'b1, -1, -1, 1'b1, 0, 1'b0, "R6");

        // R6: carrier lost after 5 bytes, no CRC
        run_frame(20, 1'b1, 1'b0, 1'b1, 5, -1, 1'b1, 5, 1'b1, "R6");

        // R6: monitoring on, carrier present, normal frame
        run_frame(12, 1'b0, 1'b0, 1'b1, -1, -1, 1'b0, 16, 1'b1, "R6");

        // R8: enable dropped mid-frame, frame still completes, then no new frame
        run_frame(30, 1'b0, 1'b0, 1'b0, -1, 3, 1'b0, 34, 1'b1, "R8");
        cfg_tx_en = 1'b0;
        src_rst = 1'b1; @(negedge clk); src_rst = 1'b0;
        frm_ready = 1'b1; seen = 0;
        repeat (40) begin @(negedge clk); if (tx_valid || buf_rd) seen++; end
        frm_ready = 1'b0;
        chk(seen == 0, "R8", "start after graceful stop", seen, 0);
        cfg_tx_en = 1'b1;

        // R9: SQE error with stop set raises the error pulse
        cfg_stop_sqe = 1'b1; seen = 0;
        @(negedge clk); sqe_err = 1'b1;
        @(negedge clk); sqe_err = 1'b0;
        if (err_clr_en) begin seen++; cfg_tx_en = 1'b0; end
        @(negedge clk); if (err_clr_en) seen++;
        chk(seen == 1, "R9", "err pulse on SQE stop", seen, 1);
        cfg_tx_en = 1'b1;

        // R9: SQE error with stop clear is ignored, next frame sent
        cfg_stop_sqe = 1'b0; seen = 0;
        @(negedge clk); sqe_err = 1'b1;
        @(negedge clk); sqe_err = 1'b0;
        if (err_clr_en) seen++;
        @(negedge clk); if (err_clr_en) seen++;
        chk(seen == 0, "R9", "err pulse with stop clear", seen, 0);
        run_frame(8, 1'b0, 1'b1, 1'b0, -1, -1, 1'b0, 8, 1'b1, "R9");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule